// File: doc/BRIEF.md
# Double-to-Int32 Saturating Converter

This block turns a 64-bit IEEE-754 double into a 32-bit two's-complement result. A format input picks between a plain signed integer and a signed fraction. The fraction has 31 bits after the binary point, so it is the input scaled by 2^31. A 2-bit input picks one of four rounding modes.

Results that cannot be represented clamp to the largest value of the right sign and raise an invalid flag. Results that are not exact raise an inexact flag.

Two trap-enable inputs shape what the block writes back:
- With invalid trapping on, an invalid conversion drops the write enable.
- With inexact trapping on, an inexact conversion writes the truncated value. The guard and sticky outputs then carry what a software handler needs to finish the rounding.

The datapath is combinational and has one output register, so results appear one cycle after `in_valid`.

Top module: `dbl2i32_cvt`

## Requirements
- R1: With `frac_mode`=0 the result is the operand rounded to a signed integer. It appears with `out_valid` high one clock after `in_valid`.
- R2: With `frac_mode`=1 the result is the operand times 2^31, rounded to a signed integer. The representable range is therefore [-1, 1-2^-31].
- R3: `rnd_mode` encodings are 00 nearest with ties to even, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R4: A rounded value above 2^31-1 gives 0x7FFFFFFF with `flag_invalid`. A rounded value below -2^31 gives 0x80000000 with `flag_invalid`. A value that rounds to exactly -2^31 is not an overflow.
- R5: NaN (exponent all ones, mantissa nonzero) and subnormal (exponent zero, mantissa nonzero) inputs give 0 with `flag_invalid`. Infinity gives the saturation value of its sign with `flag_invalid`.
- R6: Whenever `flag_invalid` is set, `guard`, `sticky` and `flag_inexact` are 0.
- R7: `wr_en` is high for a valid result unless `flag_invalid` is set while `inv_trap_en` was high. It is low when `out_valid` is low.
- R8: For a finite in-range conversion, `flag_inexact` is set exactly when any discarded bit is nonzero.
- R9: `guard` is the first discarded bit and `sticky` is the OR of all lower discarded bits. When `inx_trap_en` is high and the conversion is inexact, the result is the truncated (toward zero) value.
- R10: A zero input of either sign gives 0 with no flags and `wr_en` high.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 64 | IEEE-754 double operand |
| frac_mode | input | 1 | 0 integer result, 1 fraction result |
| rnd_mode | input | 2 | Rounding mode select |
| inv_trap_en | input | 1 | Invalid trap enable |
| inx_trap_en | input | 1 | Inexact trap enable |
| out_valid | output | 1 | Result register holds a new conversion |
| result | output | 32 | Converted value |
| wr_en | output | 1 | Destination write enable |
| flag_invalid | output | 1 | Invalid status |
| flag_inexact | output | 1 | Inexact status |
| guard | output | 1 | First discarded bit |
| sticky | output | 1 | OR of lower discarded bits |

## Verification
The bench targets several failure modes:
- Ties at every quarter step under each rounding mode. A wrong tie or direction rule moves results by one.
- Values just inside and just outside ±2^31 in both formats. An off-by-one limit either clamps -2^31 or lets 2^31 through as a wrapped negative number.
- Subnormals, NaNs and infinities under both trap settings. A misclassification leaks a stray guard bit, a wrong zero or a missing write-enable drop.
- Inexact trapping in directed rounding modes. There the truncated and rounded results differ, which exposes a design that writes the rounded value.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int EXP_W   = 11;
    localparam int MAN_W   = 52;
    localparam int SIG_W   = MAN_W + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int RES_W   = 32;
    localparam int FRAC_SH = RES_W - 1;
    localparam int EE_W    = EXP_W + 2;
    localparam int SH_W    = $clog2(SIG_W + 1);

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_ZERO = 2'b01,
        RND_POS  = 2'b10,
        RND_NEG  = 2'b11
    } rnd_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_SUBN,
        CLS_INF,
        CLS_NAN
    } cls_e;

    typedef struct packed {
        logic                   sign;
        cls_e                   cls;
        logic signed [EE_W-1:0] eff_exp;
        logic [SIG_W-1:0]       sig;
    } unpk_t;

    typedef struct packed {
        logic             sign;
        cls_e             cls;
        logic             big;
        logic [RES_W-1:0] mag;
        logic             grd;
        logic             stk;
    } algn_t;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             inv;
        logic             inx;
        logic             grd;
        logic             stk;
    } cvt_t;

    function automatic logic round_up(rnd_e m, logic neg, logic lsb,
                                      logic g, logic s);
        case (m)
            RND_NEAR: return g & (s | lsb);
            RND_ZERO: return 1'b0;
            RND_POS:  return ~neg & (g | s);
            default:  return neg & (g | s);
        endcase
    endfunction

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [63:0] op,
    input  logic        frac,
    output unpk_t       up
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic             ex_max;

    always_comb begin
        ex     = op[MAN_W +: EXP_W];
        mn     = op[MAN_W-1:0];
        ex_max = &ex;
        up.sign = op[63];
        up.sig  = {1'b1, mn};
        up.eff_exp = $signed({2'b00, ex}) - EE_W'(BIAS)
                     + (frac ? EE_W'(FRAC_SH) : '0);
        if (ex == '0)
            up.cls = (mn == '0) ? CLS_ZERO : CLS_SUBN;
        else if (ex_max)
            up.cls = (mn == '0) ? CLS_INF : CLS_NAN;
        else
            up.cls = CLS_NORM;
    end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
(
    input  unpk_t up,
    output algn_t al
);
    localparam logic signed [EE_W-1:0] TOP_E = EE_W'(RES_W - 1);
    localparam logic signed [EE_W-1:0] LOW_E = -EE_W'(1);

    logic [SH_W-1:0]  sh;
    logic [SIG_W-1:0] mask;

    always_comb begin
        al.sign = up.sign;
        al.cls  = up.cls;
        al.big  = 1'b0;
        al.mag  = '0;
        al.grd  = 1'b0;
        al.stk  = 1'b0;
        sh      = SH_W'(EE_W'(MAN_W) - up.eff_exp);
        mask    = '0;
        if (up.eff_exp > TOP_E) begin
            al.big = 1'b1;
        end else if (up.eff_exp < LOW_E) begin
            al.stk = 1'b1;
        end else begin
            mask   = (SIG_W'(1) << (sh - SH_W'(1))) - SIG_W'(1);
            al.mag = RES_W'(up.sig >> sh);
            al.grd = up.sig[sh - SH_W'(1)];
            al.stk = |(up.sig & mask);
        end
    end
endmodule

// File: rtl/fcvt_round_sat.sv
module fcvt_round_sat
    import fcvt_pkg::*;
(
    input  algn_t al,
    input  rnd_e  rm,
    input  logic  inx_trap,
    output cvt_t  cv
);
    localparam logic [RES_W:0] POS_LIM = {2'b00, {(RES_W-1){1'b1}}};
    localparam logic [RES_W:0] NEG_LIM = {2'b01, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] SAT_P = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] SAT_N = {1'b1, {(RES_W-1){1'b0}}};

    logic             inc;
    logic [RES_W:0]   mag_r;
    logic             ovf;
    logic [RES_W-1:0] sel;

    always_comb begin
        inc   = round_up(rm, al.sign, al.mag[0], al.grd, al.stk);
        mag_r = {1'b0, al.mag} + (RES_W+1)'(inc);
        ovf   = al.big | (mag_r > (al.sign ? NEG_LIM : POS_LIM));
        cv    = '0;
        sel   = '0;
        case (al.cls)
            CLS_ZERO: cv = '0;
            CLS_INF: begin
                cv.inv = 1'b1;
                cv.res = al.sign ? SAT_N : SAT_P;
            end
            CLS_NORM: begin
                if (ovf) begin
                    cv.inv = 1'b1;
                    cv.res = al.sign ? SAT_N : SAT_P;
                end else begin
                    cv.inx = al.grd | al.stk;
                    cv.grd = al.grd;
                    cv.stk = al.stk;
                    sel    = (inx_trap && cv.inx) ? al.mag : mag_r[RES_W-1:0];
                    cv.res = al.sign ? (~sel + RES_W'(1)) : sel;
                end
            end
            default: cv.inv = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbl2i32_cvt.sv
module dbl2i32_cvt
    import fcvt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] operand,
    input  logic        frac_mode,
    input  logic [1:0]  rnd_mode,
    input  logic        inv_trap_en,
    input  logic        inx_trap_en,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        wr_en,
    output logic        flag_invalid,
    output logic        flag_inexact,
    output logic        guard,
    output logic        sticky
);
    unpk_t up;
    algn_t al;
    cvt_t  cv;

    fcvt_unpack u_unpack (.op(operand), .frac(frac_mode), .up(up));
    fcvt_align  u_align  (.up(up), .al(al));
    fcvt_round_sat u_rnd (
        .al(al), .rm(rnd_e'(rnd_mode)), .inx_trap(inx_trap_en), .cv(cv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            result       <= '0;
            wr_en        <= 1'b0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            guard        <= 1'b0;
            sticky       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & ~(cv.inv & inv_trap_en);
            if (in_valid) begin
                result       <= cv.res;
                flag_invalid <= cv.inv;
                flag_inexact <= cv.inx;
                guard        <= cv.grd;
                sticky       <= cv.stk;
            end
        end
    end
endmodule

// File: rtl/dbl2i32_cvt_chk.sv
module dbl2i32_cvt_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] operand,
    input logic        inv_trap_en,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        wr_en,
    input logic        flag_invalid,
    input logic        flag_inexact,
    input logic        guard,
    input logic        sticky
);
    // R1
    lat_on_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    lat_off_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (wr_en == !(flag_invalid && $past(inv_trap_en))));
    // R7
    wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !wr_en);
    // R6
    inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> (!guard && !sticky && !flag_inexact));
    // R8
    inx_src_chk: assert property (@(posedge clk) disable iff (rst)
        flag_inexact |-> (guard || sticky));
    // R4
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_invalid && result != 32'h0) |->
            (result == 32'h7FFF_FFFF || result == 32'h8000_0000));
    // R10
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && operand[62:0] == 63'h0) |=>
            (result == 32'h0 && !flag_invalid && !flag_inexact && wr_en));
endmodule

bind dbl2i32_cvt dbl2i32_cvt_chk u_chk (.*);

// File: tb/dbl2i32_cvt_tb.sv
`timescale 1ns/1ps
module dbl2i32_cvt_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] operand;
    logic        frac_mode;
    logic [1:0]  rnd_mode;
    logic        inv_trap_en;
    logic        inx_trap_en;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_invalid;
    logic        flag_inexact;
    logic        guard;
    logic        sticky;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;
    real vals[$];

    always #10 clk = ~clk;

    dbl2i32_cvt u_dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(logic [63:0] op, logic fm, logic [1:0] rm,
                           logic it, logic xt);
        logic [10:0] ex;
        logic [51:0] mn;
        logic        e_inv, e_inx, e_g, e_s;
        logic [31:0] e_res;
        real         sc, t, a, rr, f, d, sel;
        string       tag;
        ex = op[62:52];
        mn = op[51:0];
        e_inv = 0; e_inx = 0; e_g = 0; e_s = 0; e_res = 0;
        tag = fm ? "R2 R3" : "R1 R3";
        if (ex == 0 && mn == 0) begin
            tag = "R10";
        end else if (ex == 0 || (ex == 11'h7FF && mn != 0)) begin
            tag = "R5"; e_inv = 1;
        end else if (ex == 11'h7FF) begin
            tag = "R5"; e_inv = 1;
            e_res = op[63] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end else begin
            sc = $bitstoreal(op) * (fm ? 2147483648.0 : 1.0);
            t  = (sc >= 0.0) ? $floor(sc) : $ceil(sc);
            a  = (sc >= 0.0) ? sc - t : t - sc;
            e_g = (a >= 0.5);
            e_s = ((a - (e_g ? 0.5 : 0.0)) != 0.0);
            case (rm)
                2'b00: begin
                    f = $floor(sc); d = sc - f;
                    if (d > 0.5) rr = f + 1.0;
                    else if (d < 0.5) rr = f;
                    else rr = ($floor(f / 2.0) * 2.0 != f) ? f + 1.0 : f;
                end
                2'b01: rr = t;
                2'b10: rr = $ceil(sc);
                default: rr = $floor(sc);
            endcase
            if (rr > 2147483647.0 || rr < -2147483648.0) begin
                tag = "R4"; e_inv = 1; e_g = 0; e_s = 0;
                e_res = (sc < 0.0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            end else begin
                e_inx = e_g | e_s;
                sel = rr;
                if (xt && e_inx) begin
                    sel = t; tag = "R9";
                end
                e_res = 32'($rtoi(sel));
            end
        end
        operand = op; frac_mode = fm; rnd_mode = rm;
        inv_trap_en = it; inx_trap_en = xt; in_valid = 1'b1;
        @(negedge clk);
        chk({tag, " result"}, 64'(result), 64'(e_res));
        chk("R1 out_valid", 64'(out_valid), 64'(1));
        chk("R7 wr_en", 64'(wr_en), 64'(!(e_inv && it)));
        chk("R4/R5 flag_invalid", 64'(flag_invalid), 64'(e_inv));
        chk("R8/R6 flag_inexact", 64'(flag_inexact), 64'(e_inx));
        chk("R9/R6 guard", 64'(guard), 64'(e_g));
        chk("R9/R6 sticky", 64'(sticky), 64'(e_s));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        logic [63:0] specials [8];
        rst = 1'b1; in_valid = 1'b0; operand = '0; frac_mode = 1'b0;
        rnd_mode = 2'b00; inv_trap_en = 1'b0; inx_trap_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 out_valid", 64'(out_valid), 64'(0));
        chk("R11 result", 64'(result), 64'(0));
        chk("R11 wr_en", 64'(wr_en), 64'(0));
        chk("R11 flags", 64'({flag_invalid, flag_inexact, guard, sticky}), 64'(0));

        for (int k = -48; k <= 48; k++) vals.push_back(real'(k) * 0.125);
        vals.push_back(0.001); vals.push_back(-0.001);
        vals.push_back(0.375); vals.push_back(-0.625);
        for (int sg = 0; sg < 2; sg++) begin
            real m;
            m = sg ? -1.0 : 1.0;
            vals.push_back(m * 2147483648.0);
            vals.push_back(m * 2147483647.0);
            vals.push_back(m * 2147483647.5);
            vals.push_back(m * 2147483647.25);
            vals.push_back(m * 2147483647.75);
            vals.push_back(m * 2147483648.5);
            vals.push_back(m * 2147483648.25);
            vals.push_back(m * 2147483646.5);
            vals.push_back(m * 4294967295.5);
            vals.push_back(m * 4294967296.0);
            vals.push_back(m * 1099511627776.0);
        end
        st = 32'h1234_5679;
        for (int i = 0; i < 40; i++) begin
            st = st * 32'd1664525 + 32'd1013904223;
            case (i % 3)
                0: vals.push_back(real'($signed(st)) / 7.0);
                1: vals.push_back(real'($signed(st)));
                default: vals.push_back(real'($signed(st)) * 4.0 / 3.0);
            endcase
        end

        foreach (vals[i]) begin
            for (int fm = 0; fm < 2; fm++)
                for (int rm = 0; rm < 4; rm++)
                    for (int tr = 0; tr < 4; tr++)
                        run_vec($realtobits(fm != 0 ? vals[i] / 2147483648.0 : vals[i]),
                                1'(fm), 2'(rm), tr[0], tr[1]);
        end

        specials[0] = 64'h7FF0_0000_0000_0000;
        specials[1] = 64'hFFF0_0000_0000_0000;
        specials[2] = 64'h7FF8_0000_0000_0000;
        specials[3] = 64'hFFF0_0000_0000_0001;
        specials[4] = 64'h0000_0000_0000_0001;
        specials[5] = 64'h800F_FFFF_FFFF_FFFF;
        specials[6] = 64'h8000_0000_0000_0000;
        specials[7] = 64'h0000_0000_0000_0000;
        for (int s = 0; s < 8; s++)
            for (int fm = 0; fm < 2; fm++)
                for (int rm = 0; rm < 4; rm++)
                    for (int tr = 0; tr < 4; tr++)
                        run_vec(specials[s], 1'(fm), 2'(rm), tr[0], tr[1]);

        in_valid = 1'b0;
        @(negedge clk);
        // R7 idle: no write without a conversion
        chk("R7 idle wr_en", 64'(wr_en), 64'(0));
        chk("R1 idle out_valid", 64'(out_valid), 64'(0));

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule